// File: doc/BRIEF.md
# Spare-Aware Dual Link Selector

Each processing node of a fault-tolerant two-half multistage network owns two output links and two input links. Each link lands on a different subnetwork port. Each half of the network contains one spare subnetwork of width `SUB` (√N ports), and exactly one subnetwork per half is always switched out. This block sits in one node. It decides which of the node's two output drivers is enabled and which of its two input links is listened to.

The decision follows from two indices: the disabled subnetwork on the injection side and the disabled subnetwork on the delivery side. Node `p` connects to port `p` and to port `p + SUB`. When injection-side subnetwork `j` is switched out, every node numbered below `SUB*j` uses its upper link and every other node uses its lower link. The delivery side works the same way with index `k`. Middle ports are shared by two nodes, so the unused driver must be left floating.

Both indices are loaded by a configuration strobe and held until the next accepted strobe. An index larger than `SUB` is rejected, and that half keeps its previous setting.

Top module: `dual_link_sel`

## Requirements
- R1: After reset both held indices equal `SUB`. The block then drives the upper output link (`drv_top_en=1`, `drv_bot_en=0`) and reads the upper input link (`rd_bot_sel=0`).
- R2: On an accepted injection index `j`, `drv_top_en` becomes 1 when `node_id < SUB*j` and 0 otherwise.
- R3: Exactly one of `drv_top_en` and `drv_bot_en` is 1 at all times. The other driver stays disabled (floating).
- R4: On an accepted delivery index `k`, `rd_bot_sel` becomes 1 (lower input link) when `node_id >= SUB*k` and 0 (upper link) otherwise.
- R5: Outputs change only in the cycle after a clock edge at which `cfg_load` is 1. Changes on `node_id` or on the index inputs with `cfg_load` low leave all outputs unchanged.
- R6: An index above `SUB` is rejected and its half keeps its previous selection. The two halves are validated independently, so a valid index in the other half is still taken.
- R7: Boundary indices behave as stated: index 0 selects the lower link for every node, and index `SUB` selects the upper link for every node, including node `SUB*SUB-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | $clog2(SUB*SUB) | Number of this processing node |
| cfg_load | input | 1 | Configuration strobe |
| cfg_inj_spare | input | $clog2(SUB+1) | Disabled injection-side subnetwork |
| cfg_dlv_spare | input | $clog2(SUB+1) | Disabled delivery-side subnetwork |
| drv_top_en | output | 1 | Enable for upper output link driver |
| drv_bot_en | output | 1 | Enable for lower output link driver |
| rd_bot_sel | output | 1 | 1 = read lower input link, 0 = upper |

## Verification
The injection index and the delivery index are swept over every legal value, in opposite orders. Each sweep runs for node numbers just below, at and above the multiples of `SUB`, which separates a strict from a non-strict threshold compare. Out-of-range indices are paired with valid ones in the other half, which distinguishes per-half rejection from whole-strobe rejection. Runs of cycles with the strobe low and the node number and indices changing show that nothing leaks through without a load.

// File: rtl/dual_link_pkg.sv
package dual_link_pkg;
    typedef enum logic {
        HALF_INJ = 1'b0,
        HALF_DLV = 1'b1
    } half_e;

    localparam int unsigned NUM_HALVES = 2;
endpackage

// File: rtl/dual_link_half.sv
module dual_link_half #(
    parameter int unsigned SUB = 4,
    localparam int unsigned NW = $clog2(SUB * SUB),
    localparam int unsigned IW = $clog2(SUB + 1)
) (
    input  logic [NW-1:0] node_id,
    input  logic          load,
    input  logic [IW-1:0] idx_new,
    input  logic [IW-1:0] idx_cur,
    input  logic          bot_cur,
    output logic [IW-1:0] idx_next,
    output logic          bot_next
);
    localparam int unsigned CW = NW + 1;

    logic          idx_ok;
    logic [CW-1:0] limit;

    always_comb begin
        idx_ok = (32'(idx_new) <= SUB);
        limit  = CW'(idx_new) * CW'(SUB);
        if (load && idx_ok) begin
            idx_next = idx_new;
            bot_next = (CW'(node_id) >= limit);
        end else begin
            idx_next = idx_cur;
            bot_next = bot_cur;
        end
    end
endmodule

// File: rtl/dual_link_sel.sv
module dual_link_sel #(
    parameter int unsigned SUB = 4,
    localparam int unsigned NW = $clog2(SUB * SUB),
    localparam int unsigned IW = $clog2(SUB + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] node_id,
    input  logic          cfg_load,
    input  logic [IW-1:0] cfg_inj_spare,
    input  logic [IW-1:0] cfg_dlv_spare,
    output logic          drv_top_en,
    output logic          drv_bot_en,
    output logic          rd_bot_sel
);
    import dual_link_pkg::*;

    typedef struct packed {
        logic [NUM_HALVES-1:0][IW-1:0] idx;
        logic [NUM_HALVES-1:0]         bot;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic [NUM_HALVES-1:0][IW-1:0] idx_in;
    logic [NUM_HALVES-1:0][IW-1:0] idx_nx;
    logic [NUM_HALVES-1:0]         bot_nx;

    assign idx_in[HALF_INJ] = cfg_inj_spare;
    assign idx_in[HALF_DLV] = cfg_dlv_spare;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        dual_link_half #(.SUB(SUB)) i_half (
            .node_id  (node_id),
            .load     (cfg_load),
            .idx_new  (idx_in[h]),
            .idx_cur  (st_q.idx[h]),
            .bot_cur  (st_q.bot[h]),
            .idx_next (idx_nx[h]),
            .bot_next (bot_nx[h])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.idx = idx_nx;
        st_d.bot = bot_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.idx[HALF_INJ] <= IW'(SUB);
            st_q.idx[HALF_DLV] <= IW'(SUB);
            st_q.bot           <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drv_bot_en = st_q.bot[HALF_INJ];
    assign drv_top_en = ~st_q.bot[HALF_INJ];
    assign rd_bot_sel = st_q.bot[HALF_DLV];

    // R5: without a strobe no output moves
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> ($stable(drv_top_en) && $stable(drv_bot_en) && $stable(rd_bot_sel)));

    // R6: rejected injection index keeps drivers
    p_reject_inj_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && (32'(cfg_inj_spare) > SUB)) |=> ($stable(drv_top_en) && $stable(drv_bot_en)));

    // R6: rejected delivery index keeps read select
    p_reject_dlv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && (32'(cfg_dlv_spare) > SUB)) |=> $stable(rd_bot_sel));

    // R2: node below threshold drives the upper link
    p_top_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && (32'(cfg_inj_spare) <= SUB)
         && (32'(node_id) < 32'(cfg_inj_spare) * SUB)) |=> (drv_top_en && !drv_bot_en));

    // R4: node at or above threshold reads the lower link
    p_bot_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && (32'(cfg_dlv_spare) <= SUB)
         && (32'(node_id) >= 32'(cfg_dlv_spare) * SUB)) |=> rd_bot_sel);

    // R3: exactly one driver enabled
    p_one_driver_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({drv_top_en, drv_bot_en}) == 1);
endmodule

// File: tb/test_dual_link_sel.sv
module test_dual_link_sel;
    localparam int SUB = 4;
    localparam int NW  = $clog2(SUB * SUB);
    localparam int IW  = $clog2(SUB + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] node_id = '0;
    logic          cfg_load = 1'b0;
    logic [IW-1:0] cfg_inj_spare = '0;
    logic [IW-1:0] cfg_dlv_spare = '0;
    logic          drv_top_en, drv_bot_en, rd_bot_sel;

    int errors = 0;
    int checks = 0;
    string phase = "R1";
    int m_drv_bot = 0;
    int m_rd_bot  = 0;

    always #5 clk = ~clk;

    dual_link_sel #(.SUB(SUB)) i_dual_link_sel (
        .clk(clk), .rst_n(rst_n), .node_id(node_id), .cfg_load(cfg_load),
        .cfg_inj_spare(cfg_inj_spare), .cfg_dlv_spare(cfg_dlv_spare),
        .drv_top_en(drv_top_en), .drv_bot_en(drv_bot_en), .rd_bot_sel(rd_bot_sel)
    );

    // behavioural reference, updated on every edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_drv_bot <= 0;
            m_rd_bot  <= 0;
        end else if (cfg_load) begin
            if (int'(cfg_inj_spare) <= SUB)
                m_drv_bot <= (int'(node_id) >= int'(cfg_inj_spare) * SUB) ? 1 : 0;
            if (int'(cfg_dlv_spare) <= SUB)
                m_rd_bot <= (int'(node_id) >= int'(cfg_dlv_spare) * SUB) ? 1 : 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s]: actual=%0d expected=%0d", req, phase, act, exp);
        end
    endtask

    // compare on every falling edge after reset (R2 R3 R4 under current phase)
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", int'(drv_top_en), 1 - m_drv_bot);
            chk("R3", int'(drv_bot_en), m_drv_bot);
            chk("R4", int'(rd_bot_sel), m_rd_bot);
        end
    end

    task automatic step(input int nd, input bit ld, input int inj, input int dlv);
        node_id       = NW'(nd);
        cfg_load      = ld;
        cfg_inj_spare = IW'(inj);
        cfg_dlv_spare = IW'(dlv);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1", int'(drv_top_en), 1);
        chk("R1", int'(drv_bot_en), 0);
        chk("R1", int'(rd_bot_sel), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R4/R7 sweeps over nodes around thresholds
        phase = "R7";
        for (int n = 0; n < SUB * SUB; n++) begin
            for (int j = 0; j <= SUB; j++) begin
                step(n, 1'b1, j, SUB - j);
                step(n, 1'b0, 0, 0);
            end
        end

        // R5: strobe low, inputs wander
        phase = "R5";
        step(5, 1'b1, 1, 3);
        for (int c = 0; c < 20; c++)
            step((c * 7) % (SUB * SUB), 1'b0, c % (SUB + 1), (c + 2) % (SUB + 1));

        // R6: out-of-range in one half, valid in the other
        phase = "R6";
        step(9, 1'b1, 2, 2);
        step(9, 1'b1, SUB + 1, 3);
        step(1, 1'b1, 0, SUB + 2);
        step(15, 1'b1, SUB + 3, SUB + 1);
        step(15, 1'b1, 3, 0);
        step(15, 1'b0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule